// File: doc/BRIEF.md
# Transmit Channel Fetch Admission Tracker

This block holds the admission state of one transmit DMA channel. It decides, cycle by cycle, whether the channel may start another data fetch and whether it may submit another transfer request. Admission of fetches is governed by byte occupancy of the channel's buffer. Each accepted fetch reserves one nominal burst of bytes, and drain strobes give bytes back as data leaves toward the consumer. Free space is measured against a depth that software programs. That depth may be set below the physical storage to cap buffering latency.

Admission of transfer requests is governed by a small credit counter. Software loads it while the channel is off. It falls on each accepted submission and rises on each response. Configuration is taken only while the channel enable is low. The block also flags depth settings that cannot work, such as a depth that leaves no room for a packet header ahead of the burst, or a depth beyond the physical storage. It records a sticky error when a response arrives with the credit counter already full.

Top module: `fetch_admit_tracker`

## Requirements
- R1: After reset the depth is 4096 bytes, the burst code is 1 (64 bytes), packet mode is off, the credit count is 0, free_bytes is 4096, and fetch_ok, submit_ok, cfg_err and credit_ovf are all 0.
- R2: cfg_wr loads depth, burst code, packet mode and credit count on the clock edge only while chan_en is 0. While chan_en is 1, cfg_wr has no effect on any output.
- R3: The effective depth is the smaller of the programmed depth and PHYS_BYTES (4096). free_bytes equals the effective depth minus the occupancy, or 0 when the occupancy is at least the effective depth.
- R4: fetch_ok is 1 exactly when chan_en is 1, cfg_err is 0 and free_bytes is at least the burst size. The burst size is 32 << code: code 0 = 32, 1 = 64, 2 = 128, 3 = 256 bytes.
- R5: fetch_issue while fetch_ok is 1 adds one burst size to the occupancy on the next edge. fetch_issue while fetch_ok is 0 is ignored.
- R6: drain_vld subtracts drain_bytes from the occupancy, saturating at 0. An accepted fetch and a drain in the same cycle change the occupancy by their net amount.
- R7: cfg_err is 1 when the programmed depth exceeds PHYS_BYTES. It is also 1 when the depth is below the burst size plus a margin. The margin is 2 data phases of 16 bytes (32 bytes) in packet mode and 0 otherwise.
- R8: A configuration load sets the credit count and takes precedence over strobes. submit_ok is chan_en and count nonzero. An accepted submit decrements the count, a response increments it, and both together leave it unchanged.
- R9: A response without an accepted submit, arriving while the count is at its maximum (7), leaves the count at 7 and sets credit_ovf. credit_ovf then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; configuration locked while high |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_depth | input | 13 | Depth in bytes to load |
| cfg_burst | input | 2 | Burst code to load |
| cfg_pkt_mode | input | 1 | Packet mode to load |
| cfg_credit | input | 3 | Initial credit count to load |
| fetch_issue | input | 1 | Fetch start request |
| drain_vld | input | 1 | Drain strobe |
| drain_bytes | input | 14 | Bytes drained this cycle |
| req_submit | input | 1 | Transfer request submit attempt |
| rsp_recv | input | 1 | Transfer response received |
| fetch_ok | output | 1 | Fetch permitted |
| submit_ok | output | 1 | Request submission permitted |
| free_bytes | output | 14 | Free bytes against effective depth |
| credit_cnt | output | 3 | Current credit count |
| cfg_err | output | 1 | Configuration inconsistent |
| credit_ovf | output | 1 | Sticky credit overflow error |

## Verification
The bench drains the buffer down to exactly one burst of free space and checks that permission returns there and not one byte earlier. A design that used a strict comparison would stall the channel here. The bench also issues a fetch and a drain together; a design that favoured one strobe would drift in occupancy. It over-drains to show saturation at zero, where a design without saturation would wrap to a huge occupancy and block forever. A packet-mode depth one data phase short must raise the configuration error, and a depth of exactly one burst in plain mode must not. The credit path is driven to empty, where a further submit must be refused, and to full, where a further response must set the sticky flag without wrapping the count to zero.

// File: rtl/fat_pkg.sv
package fat_pkg;

   typedef enum logic [1:0] {
      BURST_32  = 2'd0,
      BURST_64  = 2'd1,
      BURST_128 = 2'd2,
      BURST_256 = 2'd3
   } burst_code_e;

   localparam int unsigned BURST_BASE_BYTES = 32;

   function automatic int unsigned burst_size(input burst_code_e code);
      return BURST_BASE_BYTES << code;
   endfunction

endpackage

// File: rtl/fat_cfg_regs.sv
module fat_cfg_regs
   import fat_pkg::*;
#(
   parameter int unsigned DEPTH_W   = 13,
   parameter int unsigned DEPTH_RST = 4096
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               chan_en,
   input  logic               cfg_wr,
   input  logic [DEPTH_W-1:0] cfg_depth,
   input  logic [1:0]         cfg_burst,
   input  logic               cfg_pkt_mode,
   output logic               load,
   output logic [DEPTH_W-1:0] depth_q,
   output burst_code_e        burst_q,
   output logic               pkt_q
);

   localparam logic [DEPTH_W-1:0] DEPTH_INIT = DEPTH_W'(DEPTH_RST);

   initial begin
      if (DEPTH_RST >= (1 << DEPTH_W))
         $fatal(1, "fat_cfg_regs: reset depth does not fit the depth field");
   end

   assign load = cfg_wr & ~chan_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth_q <= DEPTH_INIT;
         burst_q <= BURST_64;
         pkt_q   <= 1'b0;
      end else if (load) begin
         depth_q <= cfg_depth;
         burst_q <= burst_code_e'(cfg_burst);
         pkt_q   <= cfg_pkt_mode;
      end
   end

endmodule

// File: rtl/fat_occupancy.sv
module fat_occupancy
   import fat_pkg::*;
#(
   parameter int unsigned DEPTH_W     = 13,
   parameter int unsigned PHYS_BYTES  = 4096,
   parameter int unsigned PHASE_BYTES = 16,
   parameter int unsigned HDR_PHASES  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               chan_en,
   input  logic [DEPTH_W-1:0] depth_q,
   input  burst_code_e        burst_q,
   input  logic               pkt_q,
   input  logic               fetch_issue,
   input  logic               drain_vld,
   input  logic [DEPTH_W:0]   drain_bytes,
   output logic [DEPTH_W:0]   free_bytes,
   output logic [DEPTH_W:0]   burst_bytes,
   output logic               fetch_ok,
   output logic               cfg_err
);

   localparam int unsigned OCC_W   = DEPTH_W + 1;
   localparam int unsigned SUM_W   = OCC_W + 1;
   localparam int unsigned HDR_B   = HDR_PHASES * PHASE_BYTES;
   localparam logic [OCC_W-1:0] PHYS = OCC_W'(PHYS_BYTES);

   initial begin
      if (PHYS_BYTES >= (1 << OCC_W))
         $fatal(1, "fat_occupancy: physical storage exceeds occupancy range");
      if (PHYS_BYTES < 256 + HDR_B)
         $fatal(1, "fat_occupancy: physical storage below largest burst plus header");
   end

   logic [OCC_W-1:0] occ_q;
   logic [OCC_W-1:0] eff_depth;
   logic [OCC_W-1:0] depth_ext;
   logic [SUM_W-1:0] need_bytes;
   logic [SUM_W-1:0] after_fetch;
   logic [SUM_W-1:0] drain_amt;
   logic             accept;

   assign depth_ext   = OCC_W'(depth_q);
   assign burst_bytes = OCC_W'(burst_size(burst_q));

   // Clamp only when the field can express more than the physical storage.
   generate
      if ((1 << DEPTH_W) - 1 > PHYS_BYTES) begin : g_clamp
         assign eff_depth = (depth_ext > PHYS) ? PHYS : depth_ext;
      end else begin : g_direct
         assign eff_depth = depth_ext;
      end
   endgenerate

   // Header room is only reserved for packet-mode channels.
   generate
      if (HDR_B > 0) begin : g_hdr
         assign need_bytes = SUM_W'(burst_bytes) + (pkt_q ? SUM_W'(HDR_B) : '0);
      end else begin : g_nohdr
         assign need_bytes = SUM_W'(burst_bytes);
      end
   endgenerate

   assign cfg_err    = (SUM_W'(depth_ext) < need_bytes) | (depth_ext > PHYS);
   assign free_bytes = (eff_depth > occ_q) ? (eff_depth - occ_q) : '0;
   assign fetch_ok   = chan_en & ~cfg_err & (free_bytes >= burst_bytes);
   assign accept     = fetch_issue & fetch_ok;

   assign after_fetch = SUM_W'(occ_q) + (accept ? SUM_W'(burst_bytes) : '0);
   assign drain_amt   = drain_vld ? SUM_W'(drain_bytes) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_q <= '0;
      end else if (after_fetch > drain_amt) begin
         occ_q <= OCC_W'(after_fetch - drain_amt);
      end else begin
         occ_q <= '0;
      end
   end

endmodule

// File: rtl/fat_credit.sv
module fat_credit #(
   parameter int unsigned CREDIT_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                chan_en,
   input  logic                load,
   input  logic [CREDIT_W-1:0] load_val,
   input  logic                req_submit,
   input  logic                rsp_recv,
   output logic [CREDIT_W-1:0] credit_cnt,
   output logic                submit_ok,
   output logic                credit_ovf
);

   localparam logic [CREDIT_W-1:0] CMAX = '1;

   initial begin
      if (CREDIT_W < 1 || CREDIT_W > 16)
         $fatal(1, "fat_credit: credit width out of range");
   end

   logic take;
   logic give;

   assign submit_ok = chan_en & (credit_cnt != '0);
   assign take      = req_submit & submit_ok;
   assign give      = rsp_recv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         credit_cnt <= '0;
         credit_ovf <= 1'b0;
      end else if (load) begin
         credit_cnt <= load_val;
      end else if (take && !give) begin
         credit_cnt <= credit_cnt - 1'b1;
      end else if (give && !take) begin
         if (credit_cnt == CMAX) credit_ovf <= 1'b1;
         else                    credit_cnt <= credit_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/fetch_admit_tracker.sv
module fetch_admit_tracker
   import fat_pkg::*;
#(
   parameter int unsigned DEPTH_W     = 13,
   parameter int unsigned DEPTH_RST   = 4096,
   parameter int unsigned PHYS_BYTES  = 4096,
   parameter int unsigned PHASE_BYTES = 16,
   parameter int unsigned HDR_PHASES  = 2,
   parameter int unsigned CREDIT_W    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                chan_en,
   input  logic                cfg_wr,
   input  logic [DEPTH_W-1:0]  cfg_depth,
   input  logic [1:0]          cfg_burst,
   input  logic                cfg_pkt_mode,
   input  logic [CREDIT_W-1:0] cfg_credit,
   input  logic                fetch_issue,
   input  logic                drain_vld,
   input  logic [DEPTH_W:0]    drain_bytes,
   input  logic                req_submit,
   input  logic                rsp_recv,
   output logic                fetch_ok,
   output logic                submit_ok,
   output logic [DEPTH_W:0]    free_bytes,
   output logic [CREDIT_W-1:0] credit_cnt,
   output logic                cfg_err,
   output logic                credit_ovf
);

   logic               load;
   logic [DEPTH_W-1:0] depth_q;
   burst_code_e        burst_q;
   logic               pkt_q;
   logic [DEPTH_W:0]   burst_bytes;

   fat_cfg_regs #(
      .DEPTH_W   (DEPTH_W),
      .DEPTH_RST (DEPTH_RST)
   ) u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .chan_en      (chan_en),
      .cfg_wr       (cfg_wr),
      .cfg_depth    (cfg_depth),
      .cfg_burst    (cfg_burst),
      .cfg_pkt_mode (cfg_pkt_mode),
      .load         (load),
      .depth_q      (depth_q),
      .burst_q      (burst_q),
      .pkt_q        (pkt_q)
   );

   fat_occupancy #(
      .DEPTH_W     (DEPTH_W),
      .PHYS_BYTES  (PHYS_BYTES),
      .PHASE_BYTES (PHASE_BYTES),
      .HDR_PHASES  (HDR_PHASES)
   ) u_occ (
      .clk         (clk),
      .rst_n       (rst_n),
      .chan_en     (chan_en),
      .depth_q     (depth_q),
      .burst_q     (burst_q),
      .pkt_q       (pkt_q),
      .fetch_issue (fetch_issue),
      .drain_vld   (drain_vld),
      .drain_bytes (drain_bytes),
      .free_bytes  (free_bytes),
      .burst_bytes (burst_bytes),
      .fetch_ok    (fetch_ok),
      .cfg_err     (cfg_err)
   );

   fat_credit #(
      .CREDIT_W (CREDIT_W)
   ) u_crd (
      .clk        (clk),
      .rst_n      (rst_n),
      .chan_en    (chan_en),
      .load       (load),
      .load_val   (cfg_credit),
      .req_submit (req_submit),
      .rsp_recv   (rsp_recv),
      .credit_cnt (credit_cnt),
      .submit_ok  (submit_ok),
      .credit_ovf (credit_ovf)
   );

endmodule

// File: rtl/fat_checker.sv
module fat_checker #(
   parameter int unsigned DEPTH_W    = 13,
   parameter int unsigned PHYS_BYTES = 4096,
   parameter int unsigned CREDIT_W   = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                chan_en,
   input logic                cfg_wr,
   input logic                fetch_issue,
   input logic                drain_vld,
   input logic                rsp_recv,
   input logic                fetch_ok,
   input logic [DEPTH_W:0]    free_bytes,
   input logic [DEPTH_W:0]    burst_bytes,
   input logic [CREDIT_W-1:0] credit_cnt,
   input logic                cfg_err,
   input logic                credit_ovf
);

   logic cfg_load;
   assign cfg_load = cfg_wr & ~chan_en;

   a_r3_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
      free_bytes <= (DEPTH_W+1)'(PHYS_BYTES));

   a_r4_permit_gated: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_ok |-> (chan_en && !cfg_err && free_bytes >= burst_bytes));

   a_r5_reserve: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_issue && fetch_ok && !drain_vld && !cfg_load)
      |=> free_bytes == $past(free_bytes) - $past(burst_bytes));

   a_r6_drain_grows_free: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_issue && !cfg_load) |=> free_bytes >= $past(free_bytes));

   a_r8_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (credit_cnt == '0 && !rsp_recv && !cfg_load) |=> credit_cnt == '0);

   a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      credit_ovf |=> credit_ovf);

   a_r2_locked_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && !fetch_issue && !drain_vld) |=> $stable(free_bytes));

endmodule

bind fetch_admit_tracker fat_checker #(
   .DEPTH_W    (DEPTH_W),
   .PHYS_BYTES (PHYS_BYTES),
   .CREDIT_W   (CREDIT_W)
) u_fat_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .chan_en     (chan_en),
   .cfg_wr      (cfg_wr),
   .fetch_issue (fetch_issue),
   .drain_vld   (drain_vld),
   .rsp_recv    (rsp_recv),
   .fetch_ok    (fetch_ok),
   .free_bytes  (free_bytes),
   .burst_bytes (burst_bytes),
   .credit_cnt  (credit_cnt),
   .cfg_err     (cfg_err),
   .credit_ovf  (credit_ovf)
);

// File: tb/fetch_admit_tracker_bench.sv
module fetch_admit_tracker_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_en = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [12:0] cfg_depth = '0;
   logic [1:0]  cfg_burst = '0;
   logic        cfg_pkt_mode = 1'b0;
   logic [2:0]  cfg_credit = '0;
   logic        fetch_issue = 1'b0;
   logic        drain_vld = 1'b0;
   logic [13:0] drain_bytes = '0;
   logic        req_submit = 1'b0;
   logic        rsp_recv = 1'b0;
   logic        fetch_ok, submit_ok, cfg_err, credit_ovf;
   logic [13:0] free_bytes;
   logic [2:0]  credit_cnt;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference state
   int m_depth, m_burst, m_pkt, m_occ, m_cr, m_ovf;

   always #2.5 clk = ~clk;

   fetch_admit_tracker u_fetch_admit_tracker (.*);

   function automatic int m_bb();
      return 32 << m_burst;
   endfunction
   function automatic int m_err();
      return (m_depth < m_bb() + (m_pkt ? 32 : 0)) || (m_depth > 4096);
   endfunction
   function automatic int m_free();
      int eff = (m_depth > 4096) ? 4096 : m_depth;
      return (eff > m_occ) ? eff - m_occ : 0;
   endfunction
   function automatic int m_fok();
      return chan_en && !m_err() && (m_free() >= m_bb());
   endfunction
   function automatic int m_sok();
      return chan_en && (m_cr != 0);
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R3 free_bytes", int'(free_bytes), m_free());
      chk("R4 fetch_ok", int'(fetch_ok), m_fok());
      chk("R7 cfg_err", int'(cfg_err), m_err());
      chk("R8 credit_cnt", int'(credit_cnt), m_cr);
      chk("R8 submit_ok", int'(submit_ok), m_sok());
      chk("R9 credit_ovf", int'(credit_ovf), m_ovf);
   endtask

   task automatic model_step();
      int fok = m_fok();
      int sok = m_sok();
      int ld  = cfg_wr && !chan_en;
      int sum = m_occ + ((fetch_issue && fok) ? m_bb() : 0);
      int dr  = drain_vld ? int'(drain_bytes) : 0;
      int s, r;
      m_occ = (sum > dr) ? sum - dr : 0;
      if (ld) begin
         m_cr = cfg_credit;
      end else begin
         s = req_submit && sok;
         r = rsp_recv;
         if (s && !r) m_cr--;
         else if (r && !s) begin
            if (m_cr == 7) m_ovf = 1;
            else m_cr++;
         end
      end
      if (ld) begin
         m_depth = cfg_depth;
         m_burst = cfg_burst;
         m_pkt   = cfg_pkt_mode;
      end
   endtask

   task automatic cycle();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle();
      cfg_wr = 0; fetch_issue = 0; drain_vld = 0; drain_bytes = 0;
      req_submit = 0; rsp_recv = 0;
   endtask

   task automatic configure(int d, int b, int p, int c);
      chan_en = 0; idle();
      cfg_wr = 1; cfg_depth = 13'(d); cfg_burst = 2'(b);
      cfg_pkt_mode = p[0]; cfg_credit = 3'(c);
      cycle();
      idle();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      m_depth = 4096; m_burst = 1; m_pkt = 0; m_occ = 0; m_cr = 0; m_ovf = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 free", int'(free_bytes), 4096);
      chk("R1 fetch_ok", int'(fetch_ok), 0);
      chk("R1 credit", int'(credit_cnt), 0);
      chk("R1 errs", int'(cfg_err) + int'(credit_ovf) + int'(submit_ok), 0);
      chan_en = 1; cycle();
      chk("R1 default burst permits", int'(fetch_ok), 1);

      // R2 write while enabled ignored
      cfg_wr = 1; cfg_depth = 13'd100; cfg_credit = 3'd5; cycle(); idle();
      chk("R2 depth unchanged", int'(free_bytes), 4096);
      chk("R2 credit unchanged", int'(credit_cnt), 0);

      configure(512, 2, 0, 3);
      chan_en = 1;
      // R5 reserve four bursts then block
      for (int i = 0; i < 5; i++) begin
         fetch_issue = 1; cycle();
      end
      idle(); cycle();
      chk("R5 full after four bursts", int'(free_bytes), 0);
      chk("R5 ignored issue", int'(fetch_ok), 0);
      // R4 boundary: 127 free not enough, 128 enough
      drain_vld = 1; drain_bytes = 127; cycle(); idle();
      chk("R4 one byte short", int'(fetch_ok), 0);
      drain_vld = 1; drain_bytes = 1; cycle(); idle();
      chk("R4 exact burst", int'(fetch_ok), 1);
      // R6 net issue + drain
      fetch_issue = 1; drain_vld = 1; drain_bytes = 64; cycle(); idle();
      chk("R6 net change", int'(free_bytes), 64);
      drain_vld = 1; drain_bytes = 14'd5000; cycle(); idle();
      chk("R6 saturate", int'(free_bytes), 512);

      // R8 credits
      for (int i = 0; i < 4; i++) begin
         req_submit = 1; cycle();
      end
      idle();
      chk("R8 empty", int'(credit_cnt), 0);
      chk("R8 submit blocked", int'(submit_ok), 0);
      rsp_recv = 1; cycle();
      req_submit = 1; rsp_recv = 1; cycle(); idle();
      chk("R8 both unchanged", int'(credit_cnt), 1);
      for (int i = 0; i < 6; i++) begin
         rsp_recv = 1; cycle();
      end
      idle();
      chk("R9 at max", int'(credit_cnt), 7);
      rsp_recv = 1; cycle(); idle();
      chk("R9 no wrap", int'(credit_cnt), 7);
      chk("R9 ovf set", int'(credit_ovf), 1);
      req_submit = 1; cycle(); idle(); cycle();
      chk("R9 ovf sticky", int'(credit_ovf), 1);

      // R7 configuration errors
      configure(144, 2, 1, 2); chan_en = 1; cycle();
      chk("R7 packet margin short", int'(cfg_err), 1);
      chk("R7 blocked", int'(fetch_ok), 0);
      configure(160, 2, 1, 2); chan_en = 1; cycle();
      chk("R7 packet margin exact", int'(cfg_err), 0);
      configure(5000, 3, 0, 2); chan_en = 1; cycle();
      chk("R7 above physical", int'(cfg_err), 1);
      chk("R3 clamped free", int'(free_bytes), 4096);
      configure(32, 0, 0, 2); chan_en = 1; cycle();
      chk("R7 plain exact", int'(cfg_err), 0);
      fetch_issue = 1; cycle(); cycle(); idle();
      chk("R5 single burst fills", int'(free_bytes), 0);

      // randomized traffic against the model
      configure(1024, 1, 1, 4); chan_en = 1;
      for (int i = 0; i < 2000; i++) begin
         fetch_issue = ($urandom_range(0, 2) != 0);
         drain_vld   = ($urandom_range(0, 1) != 0);
         drain_bytes = 14'($urandom_range(0, 160));
         req_submit  = ($urandom_range(0, 1) != 0);
         rsp_recv    = ($urandom_range(0, 1) != 0);
         cfg_wr      = ($urandom_range(0, 40) == 0);
         cfg_depth   = 13'($urandom_range(0, 8191));
         cfg_burst   = 2'($urandom_range(0, 3));
         cfg_pkt_mode = $urandom_range(0, 1) != 0;
         cfg_credit  = 3'($urandom_range(0, 7));
         if ($urandom_range(0, 30) == 0) chan_en = ~chan_en;
         cycle();
      end
      idle(); cycle();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule